// File: doc/BRIEF.md
# Cache-Line Advisory Lock Unit

This block holds two advisory lock bits for every line of a small direct-indexed cache. One bit marks a lock taken on behalf of other processors (the inter bit). The other marks a lock taken by tasks on this processor (the intra bit). A processor-side port presents at most one memory operation per cycle, carrying an operation code and a byte address. The block selects a line from the address, applies the fixed rule for that operation to the line's two bits, and returns a result one cycle later. Normal loads and stores always succeed. The conditional load and the store conditional report whether their lock test passed.

The block stores no data and compares no tags. Any address whose index bits match selects the same line. Software uses the result of a conditional load to decide whether to wait or to proceed; that retry policy lies outside this block.

Each line's pair of bits is held as a four-valued state. The bit order is {inter, intra}. The states are LK_FREE (00), LK_LOCAL (01, intra only), LK_STRAY (10, inter only) and LK_HELD (11). LK_STRAY is never reached from reset, but it is still handled.

The transitions are named as follows:
- grab: a conditional load on LK_FREE or LK_LOCAL goes to LK_HELD.
- refuse: a conditional load on LK_STRAY or LK_HELD stays put.
- touch: a normal load ORs in the intra bit, so LK_FREE goes to LK_LOCAL and LK_STRAY goes to LK_HELD.
- release: a normal store from any state goes to LK_FREE.
- commit: a store conditional from any state goes to LK_FREE.

Top module: `line_lock_unit`

## Requirements
- R1: A conditional load (req_op 2'b10) to a line whose inter bit is clear returns resp_ok=1 and leaves the line with both bits set.
- R2: A conditional load to a line whose inter bit is set returns resp_ok=0 and leaves both bits of the line as they were.
- R3: A normal load (2'b00) or normal store (2'b01) always returns resp_ok=1, whatever the line's lock bits are.
- R4: A normal load sets the intra bit of its line and leaves the inter bit unchanged.
- R5: A normal store clears both bits of its line.
- R6: A store conditional (2'b11) returns resp_ok=1 only when both bits of its line were set at the time of the request.
- R7: A store conditional clears both bits of its line, whether it succeeds or fails.
- R8: While rst is high at a clock edge, every line is cleared to LK_FREE and resp_valid is driven low.
- R9: The line index is req_addr[OFFSET_W+IDX_W-1:OFFSET_W], where OFFSET_W=log2(LINE_BYTES) and IDX_W=log2(NUM_LINES). Addresses with the same index share one line's lock state.
- R10: resp_valid is high in exactly the cycle after each cycle in which req_valid was high, and low otherwise.
- R11: A request issued in the cycle right after a request to the same line observes the lock state that the earlier request left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 conditional load, 11 store conditional |
| req_addr | input | ADDR_W | Byte address of the access |
| resp_valid | output | 1 | Result of the previous cycle's request |
| resp_ok | output | 1 | Success flag; always 1 for normal operations |

## Verification
Two things can fall in the same cycle: the write-back of one request's new lock state, and the read of the lock state by the next request. The bench provokes this with back-to-back requests to one line, such as two conditional loads in consecutive cycles, or a normal load followed at once by a store conditional. It also issues back-to-back requests whose addresses differ but alias to the same index. Each second result is judged against a bench model that was updated by the first request. A stale read shows up as a wrong success flag.

// File: rtl/lklock_pkg.sv
package lklock_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_CLOAD = 2'b10,
        OP_SCOND = 2'b11
    } lk_op_e;

    // bit 1 = inter-processor lock, bit 0 = intra-processor lock
    typedef enum logic [1:0] {
        LK_FREE  = 2'b00,
        LK_LOCAL = 2'b01,
        LK_STRAY = 2'b10,
        LK_HELD  = 2'b11
    } lk_state_e;

endpackage

// File: rtl/lk_index.sv
module lk_index #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int IDX_W    = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    // R9: line select sits directly above the byte offset
    assign idx = addr[OFFSET_W +: IDX_W];

    initial begin
        assert (OFFSET_W + IDX_W <= ADDR_W)
            else $error("a_r9_index_fits: index field exceeds address");
    end
endmodule

// File: rtl/lk_rules.sv
module lk_rules
    import lklock_pkg::*;
(
    input  lk_op_e    op,
    input  lk_state_e cur,
    output lk_state_e nxt,
    output logic      ok
);
    always_comb begin
        nxt = cur;
        ok  = 1'b1;
        unique case (op)
            OP_LOAD: begin
                // touch: intra bit set, inter bit kept
                unique case (cur)
                    LK_FREE, LK_LOCAL: nxt = LK_LOCAL;
                    LK_STRAY, LK_HELD: nxt = LK_HELD;
                endcase
            end
            OP_STORE: begin
                // release
                nxt = LK_FREE;
            end
            OP_CLOAD: begin
                unique case (cur)
                    LK_FREE, LK_LOCAL: begin  // grab
                        nxt = LK_HELD;
                        ok  = 1'b1;
                    end
                    LK_STRAY, LK_HELD: begin  // refuse
                        nxt = cur;
                        ok  = 1'b0;
                    end
                endcase
            end
            OP_SCOND: begin
                // commit: test both bits, always clear
                ok  = (cur == LK_HELD);
                nxt = LK_FREE;
            end
        endcase
    end
endmodule

// File: rtl/lk_array.sv
module lk_array
    import lklock_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  lk_state_e        wr_state,
    input  logic [IDX_W-1:0] rd_idx,
    output lk_state_e        rd_state,
    input  logic [IDX_W-1:0] pk_idx,
    output lk_state_e        pk_state
);
    lk_state_e line_q [NUM_LINES];

    // Same-cycle read-modify-write: the read is combinational from the
    // registered array, the write lands on the edge, so the next cycle's
    // read already sees it (R11).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) line_q[i] <= LK_FREE;  // R8
        end else if (wr_en) begin
            line_q[wr_idx] <= wr_state;
        end
    end

    assign rd_state = line_q[rd_idx];
    assign pk_state = line_q[pk_idx];
endmodule

// File: rtl/line_lock_unit.sv
module line_lock_unit
    import lklock_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_LINES  = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_ok
);
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int OFFSET_W = $clog2(LINE_BYTES);

    lk_op_e           op;
    logic [IDX_W-1:0] idx;
    lk_state_e        cur_state;
    lk_state_e        nxt_state;
    logic             rule_ok;

    // Request history kept for the checks below
    logic [IDX_W-1:0] last_idx;
    lk_op_e           last_op;
    lk_state_e        last_state;
    lk_state_e        peek_state;

    assign op = lk_op_e'(req_op);

    lk_index #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W)) u_index (
        .addr (req_addr),
        .idx  (idx)
    );

    lk_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_valid),
        .wr_idx   (idx),
        .wr_state (nxt_state),
        .rd_idx   (idx),
        .rd_state (cur_state),
        .pk_idx   (last_idx),
        .pk_state (peek_state)
    );

    lk_rules u_rules (
        .op  (op),
        .cur (cur_state),
        .nxt (nxt_state),
        .ok  (rule_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_ok    <= req_valid ? rule_ok : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx   <= '0;
            last_op    <= OP_LOAD;
            last_state <= LK_FREE;
        end else if (req_valid) begin
            last_idx   <= idx;
            last_op    <= op;
            last_state <= cur_state;
        end
    end

    a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);
    a_r3_normal_never_fails: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && (last_op == OP_LOAD || last_op == OP_STORE)) |-> resp_ok);
    a_r1_cload_grab: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_CLOAD && !last_state[1]) |-> (resp_ok && peek_state == LK_HELD));
    a_r2_cload_refuse_keeps: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_CLOAD && last_state[1]) |-> (!resp_ok && peek_state == last_state));
    a_r4_load_sets_intra: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_LOAD) |-> (peek_state[0] && peek_state[1] == last_state[1]));
    a_r5_store_clears: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_STORE) |-> (peek_state == LK_FREE));
    a_r6_scond_result: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_SCOND) |-> (resp_ok == (last_state == LK_HELD)));
    a_r7_scond_clears: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && last_op == OP_SCOND) |-> (peek_state == LK_FREE));
endmodule

// File: tb/sim_line_lock_unit.sv
module sim_line_lock_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NLINES     = 64;
    localparam int LBYTES     = 64;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [1:0]        req_op;
    logic [ADDR_W-1:0] req_addr;
    logic              resp_valid;
    logic              resp_ok;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] mdl [NLINES];   // {inter, intra}

    always #(CLK_PERIOD/2) clk = ~clk;

    line_lock_unit #(.ADDR_W(ADDR_W), .NUM_LINES(NLINES), .LINE_BYTES(LBYTES)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_ok(resp_ok)
    );

    task automatic check(input bit cond, input string rq, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] adr(input int line, input int off);
        return ADDR_W'(line * LBYTES + off);
    endfunction

    function automatic void clear_model();
        for (int i = 0; i < NLINES; i++) mdl[i] = 2'b00;
    endfunction

    // Called at a negedge; drives one request and checks its response.
    task automatic req(input logic [1:0] op, input logic [ADDR_W-1:0] a, input string rq);
        int  li;
        bit  exp_ok;
        li = int'(a[11:6]);
        exp_ok = 1'b1;
        unique case (op)
            2'b00: mdl[li][0] = 1'b1;
            2'b01: mdl[li] = 2'b00;
            2'b10: begin
                exp_ok = !mdl[li][1];
                if (exp_ok) mdl[li] = 2'b11;
            end
            2'b11: begin
                exp_ok = (mdl[li] == 2'b11);
                mdl[li] = 2'b00;
            end
        endcase
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        @(negedge clk);
        check(resp_valid == 1'b1, "R10", int'(resp_valid), 1);
        check(resp_ok == exp_ok, rq, int'(resp_ok), int'(exp_ok));
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check(resp_valid == 1'b0, "R10", int'(resp_valid), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        req_op = 2'b00;
        req_addr = '0;
        repeat (3) @(negedge clk);
        check(resp_valid == 1'b0, "R8", int'(resp_valid), 0);
        rst = 1'b0;
        clear_model();
        idle();
    endtask

    task automatic t_cload_grab();       // R1, R6
        req(2'b10, adr(3, 0), "R1");
        idle();
        req(2'b11, adr(3, 8), "R6");
        idle();
    endtask

    task automatic t_cload_refuse();     // R2, R11
        req(2'b10, adr(5, 0), "R1");
        req(2'b10, adr(5, 4), "R2");     // back-to-back, same line
        req(2'b11, adr(5, 0), "R2");     // bits still both set
        idle();
    endtask

    task automatic t_normal_ok();        // R3
        req(2'b10, adr(7, 0), "R1");
        req(2'b00, adr(7, 0), "R3");
        req(2'b10, adr(7, 0), "R2");
        req(2'b01, adr(7, 0), "R3");
        idle();
    endtask

    task automatic t_load_intra();       // R4
        req(2'b00, adr(9, 0), "R3");
        req(2'b10, adr(9, 0), "R4");     // inter still clear -> succeeds
        idle();
        req(2'b01, adr(9, 0), "R5");
        req(2'b00, adr(9, 0), "R4");
        req(2'b11, adr(9, 0), "R4");     // intra only -> fails
        idle();
    endtask

    task automatic t_store_clears();     // R5
        req(2'b10, adr(11, 0), "R1");
        req(2'b01, adr(11, 0), "R5");
        req(2'b10, adr(11, 0), "R5");
        req(2'b11, adr(11, 0), "R6");
        idle();
    endtask

    task automatic t_scond_clears();     // R6, R7
        req(2'b11, adr(13, 0), "R6");    // free -> fails
        req(2'b10, adr(13, 0), "R1");
        req(2'b11, adr(13, 0), "R6");
        req(2'b11, adr(13, 0), "R7");    // cleared by previous -> fails
        req(2'b10, adr(13, 0), "R7");    // inter clear after SC -> succeeds
        idle();
    endtask

    task automatic t_index_alias();      // R9
        req(2'b10, adr(20, 63), "R9");
        req(2'b10, adr(20 + NLINES, 0), "R9");        // aliases, refused
        req(2'b10, adr(21, 0), "R9");                 // neighbour unaffected
        req(2'b11, adr(20 + 2 * NLINES, 17), "R9");
        idle();
    endtask

    task automatic t_mid_reset();        // R8
        req(2'b10, adr(30, 0), "R1");
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R8", int'(resp_valid), 0);
        rst = 1'b0;
        clear_model();
        req(2'b10, adr(30, 0), "R8");
        idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        clear_model();
        @(negedge clk);
        t_reset();
        t_cload_grab();
        t_cload_refuse();
        t_normal_ok();
        t_load_intra();
        t_store_clears();
        t_scond_clears();
        t_index_alias();
        t_mid_reset();
        finish_run();
    end
endmodule